// File: doc/BRIEF.md
# Parallel SAR Converter Sampling Controller

This block is the host side of a 12-bit parallel successive-approximation converter. At a programmed rate it runs one full sample cycle after another. It lowers the read/convert strobe first and chip-select after a setup time. It holds both low for a minimum convert width. It then raises read/convert while keeping chip-select low, so that the converter drives its bus as soon as the conversion ends. The controller watches the converter's BUSY line through a two-flop synchronizer and waits for it to fall and then rise. It allows a bus access delay, captures the two's complement word, and releases chip-select. It then keeps the strobes quiet for a relinquish time before the bus may be used again.

Every timing limit is a count of system clock cycles set by a parameter. Captured words leave on a valid/ready stream. The output register holds one word. A word that arrives while the previous one is still waiting for the consumer is discarded and counted. If BUSY does not fall, or does not rise, within a parameterized number of cycles, a sticky error flag is set. The controller then releases the strobes and carries on with the next sample interval.

Top module: `sar_sample_ctrl`

## Requirements
- R1: During and after reset, `adc_rc_n` and `adc_cs_n` are high (1), `smp_valid` is 0, `drop_count` is 0 and `timeout_err` is 0.
- R2: `adc_cs_n` falls only after `adc_rc_n` has been low for at least SETUP_CYC consecutive cycles.
- R3: Each conversion strobe, with both `adc_rc_n` and `adc_cs_n` low, lasts at least PULSE_CYC cycles before `adc_rc_n` returns high.
- R4: Successive conversion starts (falling edges of `adc_cs_n`) are at least INTERVAL_CYC cycles apart.
- R5: A word is captured only after the synchronized BUSY has gone low and then high again. The capture happens ACCESS_CYC cycles after the controller sees the rise, with `adc_rc_n` high and `adc_cs_n` low throughout.
- R6: The captured 12-bit word appears unchanged on `smp_data`. Read as two's complement, 0x7FF is +2047, 0x800 is -2048 and 0xFFF is -1.
- R7: If BUSY does not fall within TIMEOUT_CYC cycles after the convert strobe ends, or does not rise within TIMEOUT_CYC cycles after it fell, `timeout_err` goes to 1. It stays 1 until reset, and no word is delivered for that cycle.
- R8: While `smp_valid` is 1 and `smp_ready` is 0, `smp_valid` and `smp_data` hold. A cycle with both high removes the word.
- R9: A word captured while an undelivered word is held is discarded, and `drop_count` increments by one, saturating at its maximum.
- R10: After `adc_cs_n` rises, `adc_rc_n` stays high for at least RELINQ_CYC cycles.
- R11: No new sample cycle begins while `run` is 0. A cycle already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables periodic sampling |
| adc_busy | input | 1 | Converter BUSY, asynchronous, low during a conversion |
| adc_data | input | 12 | Converter parallel data bus |
| adc_rc_n | output | 1 | Read/convert strobe, low selects convert |
| adc_cs_n | output | 1 | Chip-select strobe, active low |
| smp_valid | output | 1 | Stream word valid |
| smp_data | output | 12 | Stream word, two's complement |
| smp_ready | input | 1 | Consumer ready |
| drop_count | output | 8 | Saturating count of discarded words |
| timeout_err | output | 1 | Sticky BUSY handshake timeout flag |

## Verification
A sequencer phase counter that is loaded with the wrong length shows at the strobes within one sample interval. It shortens a setup or convert window, or brings the next chip-select fall too early, and the per-edge strobe monitors see this on the very next conversion. A wrong access wait or a missed BUSY edge delivers the converter's not-yet-valid bus pattern, which is the complement of the true word. That word reaches the stream about ten cycles after BUSY rises. A stream register that loses its hold or its drop accounting changes `smp_data` or `drop_count` within the next conversion that completes while the consumer stalls.

// File: rtl/ssc_pkg.sv
// Package: shared types and helpers of the sampling controller.
package ssc_pkg;

    // Sequencer phases of one sample cycle.
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_SETUP   = 3'd1,
        S_CONV    = 3'd2,
        S_WFALL   = 3'd3,
        S_WRISE   = 3'd4,
        S_ACCESS  = 3'd5,
        S_RELEASE = 3'd6
    } seq_state_e;

    // Larger of two integers, used for counter sizing.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssc_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the reset value is the idle level of the input.
module ssc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ssc_sequencer.sv
// Module: strobe sequencer. It walks one sample cycle: setup, convert,
// wait for BUSY low, wait for BUSY high, access delay, release and
// relinquish. It enforces the start-to-start interval and flags handshake
// timeouts.
// Assumes: all cycle parameters >= 1; busy_s is already synchronized.
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter int SETUP_CYC    = 2,
    parameter int PULSE_CYC    = 5,
    parameter int INTERVAL_CYC = 125,
    parameter int ACCESS_CYC   = 7,
    parameter int RELINQ_CYC   = 9,
    parameter int TIMEOUT_CYC  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic busy_s,
    output logic rc_n,
    output logic cs_n,
    output logic cap_en,
    output logic tmo_err
);
    localparam int MAXC = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(ACCESS_CYC, RELINQ_CYC)),
                                 max_of(INTERVAL_CYC, TIMEOUT_CYC));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE  = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_ACCESS = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] LD_RELINQ = CW'(RELINQ_CYC - 1);
    localparam logic [CW-1:0] LD_TMO    = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] LD_IVL    = CW'(INTERVAL_CYC - 1);
    localparam logic [CW-1:0] SETUP_LIM = CW'(SETUP_CYC);
    localparam logic [CW-1:0] CMAX      = CW'(MAXC);

    seq_state_e     st, st_d;
    logic [CW-1:0]  step_q, step_d;
    logic [CW-1:0]  ivl_q;
    logic           tmo_hit;

    // Next-phase decision and phase counter reload.
    always_comb begin
        st_d    = st;
        step_d  = (step_q != '0) ? step_q - 1'b1 : '0;
        cap_en  = 1'b0;
        tmo_hit = 1'b0;
        unique case (st)
            S_IDLE: if (run && ivl_q <= SETUP_LIM) begin
                st_d = S_SETUP;  step_d = LD_SETUP;
            end
            S_SETUP: if (step_q == '0) begin
                st_d = S_CONV;   step_d = LD_PULSE;
            end
            S_CONV: if (step_q == '0) begin
                st_d = S_WFALL;  step_d = LD_TMO;
            end
            S_WFALL: if (!busy_s) begin
                st_d = S_WRISE;  step_d = LD_TMO;
            end else if (step_q == '0) begin
                st_d = S_RELEASE; step_d = LD_RELINQ; tmo_hit = 1'b1;
            end
            S_WRISE: if (busy_s) begin
                st_d = S_ACCESS; step_d = LD_ACCESS;
            end else if (step_q == '0) begin
                st_d = S_RELEASE; step_d = LD_RELINQ; tmo_hit = 1'b1;
            end
            S_ACCESS: if (step_q == '0) begin
                st_d = S_RELEASE; step_d = LD_RELINQ; cap_en = 1'b1;
            end
            S_RELEASE: if (step_q == '0) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // Phase register, phase counter and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            step_q <= '0;
            rc_n   <= 1'b1;
            cs_n   <= 1'b1;
        end else begin
            st     <= st_d;
            step_q <= step_d;
            rc_n   <= !(st_d == S_SETUP || st_d == S_CONV);
            cs_n   <= !(st_d == S_CONV || st_d == S_WFALL || st_d == S_WRISE || st_d == S_ACCESS);
        end
    end

    // Start-to-start interval countdown, loaded as the convert phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ivl_q <= '0;
        else if (st_d == S_CONV && st != S_CONV) ivl_q <= LD_IVL;
        else if (ivl_q != '0)                 ivl_q <= ivl_q - 1'b1;
    end

    // Sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_err <= 1'b0;
        else if (tmo_hit) tmo_err <= 1'b1;
    end

    // ---- observation counters used only by the assertions below ----
    logic [CW-1:0] rc_low_len, both_low_len, cs_hi_len, since_start;
    logic          seen_start;

    // Track run lengths of strobe levels and time since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_low_len   <= '0;
            both_low_len <= '0;
            cs_hi_len    <= CMAX;
            since_start  <= '0;
            seen_start   <= 1'b0;
        end else begin
            rc_low_len   <= rc_n ? '0 : ((rc_low_len == CMAX) ? CMAX : rc_low_len + 1'b1);
            both_low_len <= (rc_n || cs_n) ? '0 : ((both_low_len == CMAX) ? CMAX : both_low_len + 1'b1);
            cs_hi_len    <= !cs_n ? '0 : ((cs_hi_len == CMAX) ? CMAX : cs_hi_len + 1'b1);
            if (cs_n == 1'b0 && cs_hi_len != '0) begin
                since_start <= CW'(1);
                seen_start  <= 1'b1;
            end else if (since_start != CMAX) begin
                since_start <= since_start + 1'b1;
            end
        end
    end

    p_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (rc_low_len >= CW'(SETUP_CYC)))
        else $error("R2 chip-select fell before setup time");

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_n) |-> (both_low_len >= CW'(PULSE_CYC)))
        else $error("R3 convert strobe too short");

    p_interval_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_start) |-> (since_start >= CW'(INTERVAL_CYC)))
        else $error("R4 conversion starts too close");

    p_cap_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (busy_s && !cs_n && rc_n))
        else $error("R5 capture without BUSY high and bus enabled");

    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmo_err) |-> tmo_err)
        else $error("R7 timeout flag cleared");

    p_relinq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_n) |-> (cs_hi_len >= CW'(RELINQ_CYC)))
        else $error("R10 strobe activity before bus relinquish");

    p_run_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rc_n) && $past(rc_low_len == '0)) |-> $past(run))
        else $error("R11 sample cycle started while run low");
endmodule

// File: rtl/ssc_stream_out.sv
// Module: one-word stream output register with drop accounting.
// A capture while an undelivered word waits is discarded and counted.
// Assumes: cap_en is a one-cycle pulse with bus_data valid in that cycle.
module ssc_stream_out #(
    parameter int DATA_W = 12,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] bus_data,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready,
    output logic [DROP_W-1:0] drop_cnt
);
    logic slot_free;
    assign slot_free = !m_valid || m_ready;

    // Load a new word when the slot frees, otherwise clear on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else if (cap_en && slot_free) begin
            m_valid <= 1'b1;
            m_data  <= bus_data;
        end else if (m_valid && m_ready) begin
            m_valid <= 1'b0;
        end
    end

    // Count discarded words, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   drop_cnt <= '0;
        else if (cap_en && !slot_free && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
        else $error("R8 stream word changed under backpressure");

    p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> $past(cap_en && m_valid && !m_ready))
        else $error("R9 drop counted without a blocked capture");

    p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt - $past(drop_cnt)) <= DROP_W'(1))
        else $error("R9 drop count jumped");
endmodule

// File: rtl/sar_sample_ctrl.sv
// Module: top of the parallel SAR converter sampling controller.
// Synchronizes BUSY, sequences the strobes and streams captured words.
// Assumes: timing parameters are in system clock cycles and already
// rounded up from the converter's minimum times.
module sar_sample_ctrl #(
    parameter int DATA_W       = 12,
    parameter int DROP_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int SETUP_CYC    = 2,
    parameter int PULSE_CYC    = 5,
    parameter int INTERVAL_CYC = 125,
    parameter int ACCESS_CYC   = 7,
    parameter int RELINQ_CYC   = 9,
    parameter int TIMEOUT_CYC  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_rc_n,
    output logic              adc_cs_n,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    input  logic              smp_ready,
    output logic [DROP_W-1:0] drop_count,
    output logic              timeout_err
);
    logic busy_s;
    logic cap_en;

    ssc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(adc_busy), .q(busy_s)
    );

    ssc_sequencer #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .INTERVAL_CYC(INTERVAL_CYC),
        .ACCESS_CYC(ACCESS_CYC), .RELINQ_CYC(RELINQ_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .busy_s(busy_s),
        .rc_n(adc_rc_n), .cs_n(adc_cs_n), .cap_en(cap_en), .tmo_err(timeout_err)
    );

    ssc_stream_out #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .bus_data(adc_data),
        .m_valid(smp_valid), .m_data(smp_data), .m_ready(smp_ready), .drop_cnt(drop_count)
    );

    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (adc_rc_n && adc_cs_n && !smp_valid && drop_count == '0 && !timeout_err))
        else $error("R1 outputs not idle after reset");
endmodule

// File: tb/tb_sar_sample_ctrl.sv
module tb_sar_sample_ctrl;
    localparam int SETUP_CYC = 2, PULSE_CYC = 5, INTERVAL_CYC = 125;
    localparam int RELINQ_CYC = 9, TIMEOUT_CYC = 200;
    localparam int ACCESS_NS_CYC = 6;   // model drives wrong data this long after BUSY rise

    typedef struct packed { logic [11:0] code; int sval; } vec_t;
    localparam vec_t VEC [8] = '{
        '{12'h7FF, 2047}, '{12'h800, -2048}, '{12'h000, 0}, '{12'hFFF, -1},
        '{12'h001, 1},    '{12'h555, 1365},  '{12'hAAA, -1366}, '{12'h7FE, 2046}
    };

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, smp_ready = 1'b1;
    logic adc_busy, adc_rc_n, adc_cs_n, smp_valid, timeout_err;
    logic [11:0] adc_data, smp_data;
    logic [7:0] drop_count;

    always #5 clk = ~clk;

    sar_sample_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run(run), .adc_busy(adc_busy), .adc_data(adc_data),
        .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .drop_count(drop_count), .timeout_err(timeout_err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] code_of(input int k);
        if (k < 8) return VEC[k].code;
        return 12'((k * 293 + 91) % 4096);
    endfunction

    // ---------------- behavioural converter model ----------------
    typedef enum logic [1:0] {M_IDLE, M_PRE, M_CONV} mst_e;
    localparam int MODE_OK = 0, MODE_NOFALL = 1, MODE_NORISE = 2;
    int   mode = MODE_OK;
    mst_e mst;
    int   mcnt, mstarts, since_rise;
    logic [11:0] m_word, m_next;
    logic prev_both;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst <= M_IDLE; adc_busy <= 1'b1; mstarts <= 0; since_rise <= 100;
            m_word <= 12'h000; prev_both <= 1'b0; mcnt <= 0;
        end else begin
            prev_both  <= !adc_cs_n && !adc_rc_n;
            since_rise <= (since_rise < 100) ? since_rise + 1 : since_rise;
            case (mst)
                M_IDLE: if (!adc_cs_n && !adc_rc_n && !prev_both && adc_busy) begin
                    m_next  <= code_of(mstarts);
                    mstarts <= mstarts + 1;
                    mcnt    <= $urandom_range(11, 2);
                    if (mode != MODE_NOFALL) mst <= M_PRE;
                end
                M_PRE: if (mcnt <= 1) begin
                    adc_busy <= 1'b0; mcnt <= $urandom_range(107, 90); mst <= M_CONV;
                end else mcnt <= mcnt - 1;
                M_CONV: if (mcnt <= 1) begin
                    if (mode != MODE_NORISE) begin
                        adc_busy <= 1'b1; m_word <= m_next; since_rise <= 0; mst <= M_IDLE;
                    end
                end else mcnt <= mcnt - 1;
                default: mst <= M_IDLE;
            endcase
        end
    end

    // Bus: complement of the word until the access time has passed.
    assign adc_data = (adc_busy && !adc_cs_n && adc_rc_n)
                      ? ((since_rise < ACCESS_NS_CYC) ? ~m_word : m_word) : 12'hA5A;

    // ---------------- strobe timing monitor ----------------
    int rc_low, both_low, cs_hi, since_st, v2, v3, v4, v10, nstarts;
    bit had_st;
    logic p_rc, p_cs;
    always @(negedge clk) begin
        if (!rst_n) begin
            rc_low <= 0; both_low <= 0; cs_hi <= 1000; since_st <= 0; had_st <= 0;
            p_rc <= 1'b1; p_cs <= 1'b1;
        end else begin
            if (p_cs && !adc_cs_n) begin
                nstarts <= nstarts + 1;
                if (rc_low < SETUP_CYC) v2 <= v2 + 1;
                if (had_st && since_st < INTERVAL_CYC) v4 <= v4 + 1;
            end
            if (!p_rc && adc_rc_n && both_low < PULSE_CYC) v3 <= v3 + 1;
            if (p_rc && !adc_rc_n && cs_hi < RELINQ_CYC) v10 <= v10 + 1;
            rc_low   <= adc_rc_n ? 0 : rc_low + 1;
            both_low <= (adc_rc_n || adc_cs_n) ? 0 : both_low + 1;
            cs_hi    <= adc_cs_n ? cs_hi + 1 : 0;
            if (p_cs && !adc_cs_n) begin since_st <= 1; had_st <= 1; end
            else since_st <= since_st + 1;
            p_rc <= adc_rc_n; p_cs <= adc_cs_n;
        end
    end
    initial begin v2 = 0; v3 = 0; v4 = 0; v10 = 0; nstarts = 0; end

    task automatic wait_valid(input string req);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (smp_valid) return;
        end
        chk(1'b0, req, 0, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int kbase;
        logic [11:0] held;
        repeat (3) @(negedge clk);
        chk(adc_rc_n && adc_cs_n, "R1 strobes high in reset", {adc_rc_n, adc_cs_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_rc_n && adc_cs_n && !smp_valid, "R1 idle after reset", {adc_rc_n, adc_cs_n, smp_valid}, 6);
        chk(drop_count == 0 && !timeout_err, "R1 counters clear", drop_count, 0);

        // R11: run low, nothing starts
        repeat (300) @(negedge clk);
        chk(mstarts == 0 && adc_cs_n, "R11 no start while run low", mstarts, 0);

        // Table walk: R6 values and two's complement reading, R5 access timing
        run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_valid("R6 sample missing");
            chk(smp_data == VEC[i].code, "R6 R5 captured code", smp_data, VEC[i].code);
            chk($signed(smp_data) == VEC[i].sval, "R6 signed value", $signed(smp_data), VEC[i].sval);
        end
        run = 1'b0;
        repeat (300) @(negedge clk);
        chk(drop_count == 0, "R9 no drops with ready high", drop_count, 0);

        // Backpressure: hold, drop newest, R8 and R9
        kbase = mstarts;
        smp_ready = 1'b0;
        run = 1'b1;
        while (mstarts < kbase + 4) @(negedge clk);
        run = 1'b0;
        repeat (250) @(negedge clk);
        held = code_of(kbase);
        chk(smp_valid == 1'b1, "R8 word held under backpressure", smp_valid, 1);
        chk(smp_data == held, "R8 held word is the oldest", smp_data, held);
        chk(drop_count == 3, "R9 three newer words dropped", drop_count, 3);
        smp_ready = 1'b1;
        @(negedge clk);
        chk(smp_valid == 1'b0, "R8 handshake removes word", smp_valid, 0);
        repeat (200) @(negedge clk);
        chk(mstarts == kbase + 4, "R11 run low stops new cycles", mstarts, kbase + 4);

        // Timing minima over all conversions so far
        chk(nstarts >= 12, "R4 enough starts observed", nstarts, 12);
        chk(v2 == 0, "R2 setup before chip-select", v2, 0);
        chk(v3 == 0, "R3 convert pulse width", v3, 0);
        chk(v4 == 0, "R4 start-to-start interval", v4, 0);
        chk(v10 == 0, "R10 relinquish before next strobe", v10, 0);

        // R7: BUSY never falls
        mode = MODE_NOFALL;
        do_reset();
        run = 1'b1;
        repeat (TIMEOUT_CYC + 150) @(negedge clk);
        chk(timeout_err == 1'b1, "R7 timeout when BUSY never falls", timeout_err, 1);
        chk(smp_valid == 1'b0, "R7 no word after fall timeout", smp_valid, 0);
        repeat (300) @(negedge clk);
        chk(timeout_err == 1'b1, "R7 flag sticky", timeout_err, 1);

        // R7: BUSY never rises
        run = 1'b0;
        mode = MODE_NORISE;
        do_reset();
        chk(timeout_err == 1'b0 && adc_cs_n && adc_rc_n, "R1 reset clears flag", timeout_err, 0);
        run = 1'b1;
        repeat (2 * TIMEOUT_CYC + 200) @(negedge clk);
        chk(timeout_err == 1'b1, "R7 timeout when BUSY never rises", timeout_err, 1);
        chk(smp_valid == 1'b0, "R7 no word after rise timeout", smp_valid, 0);

        // Recovery to normal operation
        run = 1'b0;
        mode = MODE_OK;
        do_reset();
        run = 1'b1;
        wait_valid("R6 sample after recovery");
        chk(smp_data == code_of(0), "R6 first word after reset", smp_data, code_of(0));
        chk(timeout_err == 1'b0, "R7 no flag on good cycle", timeout_err, 0);
        run = 1'b0;
        repeat (300) @(negedge clk);
        chk(v2 == 0 && v3 == 0 && v4 == 0 && v10 == 0, "R2 R3 R4 R10 minima in all phases",
            v2 + v3 + v4 + v10, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule